// File: doc/BRIEF.md
# SPI Byte Transceiver (master or slave)

This block moves one byte at a time over a four-wire serial link and can take either side of it. With `cfg_master` set, it generates the serial clock and a low-active select. A processor-side write of a transmit byte is the only thing that starts a transfer. Every transfer shifts a byte out and a byte in at the same time, so a receive-only transfer is started by writing a dummy byte. With `cfg_master` clear, the block follows an external clock. It brings that clock and the incoming data into the system clock domain through flop synchronizers. It shifts out whatever byte software loaded before the first incoming edge.

Both directions share one shift engine. Clock polarity and phase select the sampling edge and the shifting edge. A completed byte is copied into a one-byte holding register and raises a full flag and a one-cycle interrupt. A later byte simply replaces an unread one. In master mode, a write made while a byte is in flight queues the next byte. That byte follows without a gap in the clock rhythm.

Top module: `spi_xcvr`

## Requirements
- R1: In master mode a `wr_tx` pulse while idle makes `busy` 1 and `cs_n_o` 0 from the next cycle. Exactly 16 transitions of `sck_o` follow, and `busy` returns to 0 at the last transition.
- R2: `sck_o` rests at `cfg_cpol` whenever the master is idle. Data goes most significant bit first. The sampling edge is the first edge of each clock pulse when `cfg_cpha`=0 and the second edge when `cfg_cpha`=1. With `sdo_o` looped to `sdi_i`, the received byte equals the sent byte in all four modes.
- R3: In master mode with `cfg_cpha`=0, the first `sck_o` transition comes one system cycle after `cs_n_o` falls and the first bit appears. With `cfg_cpha`=1, the first transition comes N cycles after.
- R4: In master mode, each half period of `sck_o` lasts N system cycles, where N is `cfg_div`, and a value of 0 acts as 1. This spacing also holds from the last edge of one byte to the first edge of a queued byte.
- R5: When the eighth bit is sampled, the byte appears on `rx_data` in the same cycle that `rx_full` becomes 1.
- R6: A `rd_rx` pulse clears `rx_full` unless a byte completes in that same cycle.
- R7: `irq` is a one-cycle pulse whenever a byte is delivered while `rx_full` is 0. It also pulses when a delivery coincides with `rd_rx`, and in that case `rx_full` stays 1 with the new byte.
- R8: A byte that completes while `rx_full` is 1 and no read occurs replaces the held byte, with no second `irq` and no error indication.
- R9: A `wr_tx` pulse during a master transfer queues that byte. It is sent right after the current byte, `busy` stays 1 throughout, and the burst carries 32 transitions.
- R10: In slave mode, 8 bits clocked in on `sck_i`/`sdi_i` in any of the four modes land in `rx_data`. A byte written beforehand is returned on `sdo_o`, most significant bit first.
- R11: In slave mode, `busy` is 0, `cs_n_o` is 1 and `sck_o` equals `cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 selects master, 0 selects slave |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0 samples on the first edge of a pulse, 1 on the second edge |
| cfg_div | input | DIV_W | Master half period in system cycles (0 acts as 1) |
| wr_tx | input | 1 | Transmit byte write strobe |
| wr_data | input | DATA_W | Transmit byte |
| rd_rx | input | 1 | Receive byte read strobe |
| rx_data | output | DATA_W | Held received byte |
| rx_full | output | 1 | Held byte is unread |
| busy | output | 1 | Master transfer in progress |
| irq | output | 1 | One-cycle pulse on a new received byte |
| sck_o | output | 1 | Serial clock driven in master mode |
| cs_n_o | output | 1 | Select driven in master mode, active low |
| sdo_o | output | 1 | Serial data out |
| sck_i | input | 1 | Serial clock from an external master |
| sdi_i | input | 1 | Serial data in |

## Verification
The two functions that can meet in one cycle are the delivery of a freshly completed byte into the holding register and a software read of that register. The bench first leaves one byte unread. It then counts `sck_o` transitions of the next transfer, which lets it place a one-cycle `rd_rx` exactly on the cycle where the eighth bit is sampled. It judges the result in three ways. The read must return the old byte in that cycle. Afterwards `rx_full` must still be 1 and hold the new byte. An `irq` pulse must appear even though the flag never dropped.

// File: rtl/spi_pkg.sv
package spi_pkg;

   typedef struct packed {
      logic master;
      logic cpol;
      logic cpha;
   } spi_cfg_t;

   // which clock edge classes sample and shift for a given phase setting
   function automatic logic samples_on_lead(input logic cpha);
      return !cpha;
   endfunction

endpackage

// File: rtl/spi_mseq.sv
module spi_mseq #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cpha,
   input  logic [DIV_W-1:0]  div,
   input  logic              wr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              phase,
   output logic              start,
   output logic              load,
   output logic [DATA_W-1:0] load_data,
   output logic              lead_ev,
   output logic              trail_ev
);
   localparam int unsigned EDGES = 2 * DATA_W;
   localparam int unsigned EW    = $clog2(EDGES);
   localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

   logic              run_q;
   logic [DIV_W-1:0]  hcnt_q;
   logic [EW-1:0]     eidx_q;
   logic              phase_q;
   logic              pend_v_q;
   logic [DATA_W-1:0] pend_q;
   logic [DIV_W-1:0]  half;
   logic              edge_now;
   logic              last_edge;

   assign half      = (div == '0) ? '0 : div - DIV_W'(1);
   assign edge_now  = run_q && (hcnt_q == '0);
   assign last_edge = edge_now && (eidx_q == LAST_EDGE);
   assign lead_ev   = edge_now && !eidx_q[0];
   assign trail_ev  = edge_now &&  eidx_q[0];
   assign start     = en && wr && !run_q;
   assign load      = start || (last_edge && (pend_v_q || wr));
   assign load_data = (start || !pend_v_q) ? wr_data : pend_q;
   assign busy      = run_q;
   assign phase     = phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         hcnt_q   <= '0;
         eidx_q   <= '0;
         phase_q  <= 1'b0;
         pend_v_q <= 1'b0;
         pend_q   <= '0;
      end else if (!en) begin
         run_q    <= 1'b0;
         phase_q  <= 1'b0;
         pend_v_q <= 1'b0;
      end else begin
         if (start) begin
            run_q   <= 1'b1;
            eidx_q  <= '0;
            phase_q <= 1'b0;
            hcnt_q  <= cpha ? half : '0;
         end else if (edge_now) begin
            phase_q <= ~phase_q;
            hcnt_q  <= half;
            if (last_edge) begin
               eidx_q <= '0;
               if (!(pend_v_q || wr)) run_q <= 1'b0;
            end else begin
               eidx_q <= eidx_q + EW'(1);
            end
         end else if (run_q) begin
            hcnt_q <= hcnt_q - DIV_W'(1);
         end

         if (last_edge) begin
            pend_v_q <= pend_v_q && wr;
            if (wr) pend_q <= wr_data;
         end else if (wr && run_q) begin
            pend_v_q <= 1'b1;
            pend_q   <= wr_data;
         end
      end
   end
endmodule

// File: rtl/spi_sfront.sv
module spi_sfront #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic cpol,
   input  logic sck_in,
   input  logic sd_in,
   output logic lead_ev,
   output logic trail_ev,
   output logic sd_sync
);
   localparam int unsigned S = SYNC_STAGES;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_sfront: SYNC_STAGES must be at least 2");
   end

   logic [S:0]   sck_q;
   logic [S-1:0] sd_q;
   logic         rise;
   logic         fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= '0;
         sd_q  <= '0;
      end else if (!en) begin
         sck_q <= {(S+1){cpol}};
         sd_q  <= '0;
      end else begin
         sck_q <= {sck_q[S-1:0], sck_in};
         sd_q  <= {sd_q[S-2:0], sd_in};
      end
   end

   assign rise     =  sck_q[S-1] & ~sck_q[S];
   assign fall     = ~sck_q[S-1] &  sck_q[S];
   assign lead_ev  = en && (cpol ? fall : rise);
   assign trail_ev = en && (cpol ? rise : fall);
   assign sd_sync  = sd_q[S-1];
endmodule

// File: rtl/spi_shift.sv
module spi_shift
   import spi_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpha,
   input  logic              lead_ev,
   input  logic              trail_ev,
   input  logic              din,
   input  logic              clr,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic              dout,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte
);
   localparam int unsigned CW = $clog2(DATA_W);
   localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;
   logic [CW-1:0]     cnt_q;
   logic              sample_ev;
   logic              shift_ev;

   assign sample_ev = samples_on_lead(cpha) ? lead_ev : trail_ev;
   assign shift_ev  = samples_on_lead(cpha) ? trail_ev : lead_ev;
   assign done      = sample_ev && (cnt_q == LAST_BIT);
   assign rx_byte   = {rx_q[DATA_W-2:0], din};
   assign dout      = tx_q[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q  <= '0;
         rx_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (clr) begin
            cnt_q <= '0;
         end else if (sample_ev) begin
            rx_q  <= {rx_q[DATA_W-2:0], din};
            cnt_q <= (cnt_q == LAST_BIT) ? '0 : cnt_q + CW'(1);
         end

         if (load) begin
            tx_q <= load_data;
         end else if (shift_ev && !(cpha && cnt_q == '0)) begin
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/spi_rxbuf.sv
module spi_rxbuf #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] new_byte,
   input  logic              rd,
   output logic [DATA_W-1:0] data,
   output logic              full,
   output logic              irq
);
   logic [DATA_W-1:0] hold_q;
   logic              full_q;
   logic              irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         full_q <= 1'b0;
         irq_q  <= 1'b0;
      end else if (done) begin
         hold_q <= new_byte;
         full_q <= 1'b1;
         irq_q  <= !full_q || rd;
      end else begin
         irq_q <= 1'b0;
         if (rd) full_q <= 1'b0;
      end
   end

   assign data = hold_q;
   assign full = full_q;
   assign irq  = irq_q;
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
   import spi_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              wr_tx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_rx,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              busy,
   output logic              irq,
   output logic              sck_o,
   output logic              cs_n_o,
   output logic              sdo_o,
   input  logic              sck_i,
   input  logic              sdi_i
);
   if (DATA_W < 2) begin : g_bad_width
      $error("spi_xcvr: DATA_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("spi_xcvr: DIV_W must be at least 1");
   end

   spi_cfg_t cfg;
   assign cfg = '{master: cfg_master, cpol: cfg_cpol, cpha: cfg_cpha};

   logic              m_busy, m_phase, m_start, m_load, m_lead, m_trail;
   logic [DATA_W-1:0] m_load_data;
   logic              s_lead, s_trail, s_sd;
   logic              rx_done;
   logic [DATA_W-1:0] rx_byte;

   spi_mseq #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_mseq (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cfg.master),
      .cpha      (cfg.cpha),
      .div       (cfg_div),
      .wr        (wr_tx),
      .wr_data   (wr_data),
      .busy      (m_busy),
      .phase     (m_phase),
      .start     (m_start),
      .load      (m_load),
      .load_data (m_load_data),
      .lead_ev   (m_lead),
      .trail_ev  (m_trail)
   );

   spi_sfront #(.SYNC_STAGES(SYNC_STAGES)) u_sfront (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (!cfg.master),
      .cpol     (cfg.cpol),
      .sck_in   (sck_i),
      .sd_in    (sdi_i),
      .lead_ev  (s_lead),
      .trail_ev (s_trail),
      .sd_sync  (s_sd)
   );

   spi_shift #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpha      (cfg.cpha),
      .lead_ev   (cfg.master ? m_lead  : s_lead),
      .trail_ev  (cfg.master ? m_trail : s_trail),
      .din       (cfg.master ? sdi_i   : s_sd),
      .clr       (m_start),
      .load      (cfg.master ? m_load  : wr_tx),
      .load_data (cfg.master ? m_load_data : wr_data),
      .dout      (sdo_o),
      .done      (rx_done),
      .rx_byte   (rx_byte)
   );

   spi_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (rx_done),
      .new_byte (rx_byte),
      .rd       (rd_rx),
      .data     (rx_data),
      .full     (rx_full),
      .irq      (irq)
   );

   assign busy   = m_busy;
   assign sck_o  = cfg.master ? (m_phase ^ cfg.cpol) : cfg.cpol;
   assign cs_n_o = !(cfg.master && m_busy);
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_master,
   input logic cfg_cpol,
   input logic wr_tx,
   input logic rd_rx,
   input logic busy,
   input logic rx_full,
   input logic irq,
   input logic sck_o,
   input logic byte_done
);
   // R1: a transfer begins only after a transmit write
   a_r1_start_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_tx));

   // R2: idle master clock rests at the polarity setting
   a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && !busy && $stable(cfg_cpol)) |-> (sck_o == cfg_cpol));

   // R5: a completed byte marks the buffer full
   a_r5_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> rx_full);

   // R6: a read without a colliding delivery empties the buffer
   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rx && !byte_done) |=> !rx_full);

   // R7: flag rising is always announced
   a_r7_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> irq);

   // R7: the pulse never appears with an empty buffer
   a_r7_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> rx_full);

   // R7: the pulse lasts a single cycle
   a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
endmodule

bind spi_xcvr spi_xcvr_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_master (cfg_master),
   .cfg_cpol   (cfg_cpol),
   .wr_tx      (wr_tx),
   .rd_rx      (rd_rx),
   .busy       (busy),
   .rx_full    (rx_full),
   .irq        (irq),
   .sck_o      (sck_o),
   .byte_done  (rx_done)
);

// File: tb/spi_xcvr_tb.sv
`timescale 1ns/1ps
module spi_xcvr_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
   logic [7:0] cfg_div = 8'd2;
   logic       wr_tx = 1'b0, rd_rx = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rx_data;
   logic       rx_full, busy, irq, sck_o, cs_n_o, sdo_o;
   logic       sck_i = 1'b0, sdi_i = 1'b0;
   logic       loop_en = 1'b1;

   int total = 0, bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   spi_xcvr u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .wr_tx(wr_tx), .wr_data(wr_data),
      .rd_rx(rd_rx), .rx_data(rx_data), .rx_full(rx_full), .busy(busy), .irq(irq),
      .sck_o(sck_o), .cs_n_o(cs_n_o), .sdo_o(sdo_o), .sck_i(sck_i),
      .sdi_i(loop_en ? sdo_o : sdi_i)
   );

   // observation of serial clock timing, interrupts and busy drops
   int cyc = 0, cs_cyc = 0, last_tog = 0;
   int tog_burst = 0, first_gap = 0, gmin = 0, gmax = 0;
   int irq_cnt = 0, busy_falls = 0;
   logic prev_cs = 1'b1, prev_sck = 1'b0, prev_busy = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (irq) irq_cnt = irq_cnt + 1;
      if (prev_busy && !busy) busy_falls = busy_falls + 1;
      if (prev_cs && !cs_n_o) begin
         cs_cyc = cyc; tog_burst = 0; gmin = 1000000; gmax = 0;
      end
      if (!cs_n_o || (prev_sck != sck_o && !prev_cs)) begin
         if (sck_o != prev_sck) begin
            if (tog_burst == 0) first_gap = cyc - cs_cyc;
            else begin
               if (cyc - last_tog < gmin) gmin = cyc - last_tog;
               if (cyc - last_tog > gmax) gmax = cyc - last_tog;
            end
            tog_burst = tog_burst + 1;
            last_tog  = cyc;
         end
      end
      prev_cs = cs_n_o; prev_sck = sck_o; prev_busy = busy;
   end

   task automatic tick;
      @(negedge clk); #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] d);
      tick; wr_tx = 1'b1; wr_data = d;
      tick; wr_tx = 1'b0;
   endtask

   task automatic do_read;
      rd_rx = 1'b1; tick; rd_rx = 1'b0;
   endtask

   task automatic wait_idle;
      for (int i = 0; i < 2000 && busy; i++) tick;
   endtask

   task automatic set_mode(input logic m, input logic pol, input logic pha, input logic [7:0] dv);
      cfg_master = 1'b1; cfg_cpol = pol; cfg_cpha = pha; cfg_div = dv;
      sck_i = pol; sdi_i = 1'b0;
      repeat (4) tick;
      cfg_master = m;
      repeat (4) tick;
   endtask

   // external master driving the block in slave mode, half period of 8 cycles
   task automatic ext_xfer(input logic [7:0] mo, output logic [7:0] got);
      got = 8'h00;
      for (int b = 7; b >= 0; b--) begin
         if (!cfg_cpha) begin
            sdi_i = mo[b];
            repeat (8) tick;
            got = {got[6:0], sdo_o};
            sck_i = ~cfg_cpol;
            repeat (8) tick;
            sck_i = cfg_cpol;
         end else begin
            sck_i = ~cfg_cpol; sdi_i = mo[b];
            repeat (8) tick;
            got = {got[6:0], sdo_o};
            sck_i = cfg_cpol;
            repeat (8) tick;
         end
      end
      repeat (8) tick;
   endtask

   // {cpol, cpha, div, data}
   localparam logic [17:0] VEC [0:5] = '{
      {1'b0, 1'b0, 8'd2, 8'hA5},
      {1'b0, 1'b1, 8'd3, 8'h3C},
      {1'b1, 1'b0, 8'd1, 8'h81},
      {1'b1, 1'b1, 8'd4, 8'h5E},
      {1'b0, 1'b0, 8'd0, 8'hFF},
      {1'b1, 1'b1, 8'd0, 8'h00}
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] got;
      int irq0, bf0, n;
      repeat (3) tick;
      // reset state
      chk("R1 reset busy", busy, 0);
      chk("R1 reset cs", cs_n_o, 1);
      chk("R5 reset full", rx_full, 0);
      chk("R7 reset irq", irq, 0);
      rst_n = 1'b1;
      repeat (2) tick;
      chk("R2 reset idle sck", sck_o, 0);

      // master loopback over all modes and dividers
      foreach (VEC[i]) begin
         set_mode(1'b1, VEC[i][17], VEC[i][16], VEC[i][15:8]);
         n = (VEC[i][15:8] == 0) ? 1 : int'(VEC[i][15:8]);
         irq0 = irq_cnt;
         do_write(VEC[i][7:0]);
         chk("R1 busy after write", busy, 1);
         chk("R1 cs low", cs_n_o, 0);
         wait_idle;
         tick;
         chk("R2 loopback byte", rx_data, VEC[i][7:0]);
         chk("R5 full set", rx_full, 1);
         chk("R1 transitions", tog_burst, 16);
         chk("R3 first edge delay", first_gap, VEC[i][16] ? n : 1);
         chk("R4 min half period", gmin, n);
         chk("R4 max half period", gmax, n);
         chk("R2 idle level", sck_o, VEC[i][17]);
         chk("R7 irq pulses", irq_cnt - irq0, 1);
         do_read;
         chk("R6 read clears", rx_full, 0);
      end

      // R8: overwrite of an unread byte
      set_mode(1'b1, 1'b0, 1'b0, 8'd2);
      irq0 = irq_cnt;
      do_write(8'h11); wait_idle;
      do_write(8'h22); wait_idle; tick;
      chk("R8 newest byte kept", rx_data, 8'h22);
      chk("R8 flag stays", rx_full, 1);
      chk("R8 no second irq", irq_cnt - irq0, 1);

      // R7: read lands on the delivery cycle
      set_mode(1'b1, 1'b0, 1'b0, 8'd4);
      irq0 = irq_cnt;
      do_write(8'h6D);
      for (int k = 0; k < 500 && tog_burst != 14; k++) tick;
      repeat (3) tick;
      rd_rx = 1'b1;
      chk("R7 read returns old byte", rx_data, 8'h22);
      tick; rd_rx = 1'b0;
      wait_idle; tick;
      chk("R7 collision flag", rx_full, 1);
      chk("R7 collision data", rx_data, 8'h6D);
      chk("R7 collision irq", irq_cnt - irq0, 1);
      do_read;

      // R9: queued byte during a transfer
      set_mode(1'b1, 1'b1, 1'b1, 8'd3);
      bf0 = busy_falls;
      do_write(8'h4B);
      repeat (5) tick;
      do_write(8'hD2);
      wait_idle; tick;
      chk("R9 burst transitions", tog_burst, 32);
      chk("R9 single busy drop", busy_falls - bf0, 1);
      chk("R9 spacing min", gmin, 3);
      chk("R9 spacing max", gmax, 3);
      chk("R9 last byte", rx_data, 8'hD2);
      do_read;

      // R10 / R11: slave mode in all four modes
      loop_en = 1'b0;
      for (int m = 0; m < 4; m++) begin
         set_mode(1'b0, m[1], m[0], 8'd2);
         do_write(8'hC3 ^ 8'(m * 5));
         ext_xfer(8'h96 + 8'(m * 17), got);
         chk("R10 slave rx", rx_data, 8'h96 + 8'(m * 17));
         chk("R10 slave tx", got, 8'hC3 ^ 8'(m * 5));
         chk("R5 slave full", rx_full, 1);
         chk("R11 slave busy", busy, 0);
         chk("R11 slave cs", cs_n_o, 1);
         chk("R11 slave sck", sck_o, m[1]);
         do_read;
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule